// File: doc/BRIEF.md
# Register-Mapped Serial Port (Transmit and Receive)

This block is an asynchronous serial transmitter and receiver pair placed behind a small strobe-driven register bus. Software reaches it with a byte-wide bus made of an address, a read strobe, a write strobe, write data and read data. Each direction has its own bank of registers, selected by the top address bit. A bank holds an enable switch, a divisor that sets the bit period in system clocks, a ready flag and a data byte.

The transmitter turns a written byte into a frame on the serial output: a low start bit, eight data bits least significant first, and a high stop bit. The receiver watches the serial input through a two-stage synchronizer. It finds a start bit by its falling edge, samples every bit near the middle of its period, and hands the byte to a holding register, where it stays until software reads it.

Top module: `uart_csr_periph`

## Requirements
- R1: Address bit 4 selects the bank (0 = receive, 1 = transmit). Bits 3:0 are the offset: 0x0 config (bit 0 = enable), 0x4..0x7 divisor bytes in little-endian order (0x4 is the least significant), 0x8 status (bit 0 = ready), 0x9 data byte.
- R2: Read data is registered. It is valid on the clock after the read strobe and holds its value until the next read. Offsets 0x1..0x3 and 0xA..0xF read 0 and ignore writes, and the transmit data offset reads 0.
- R3: Both divisors reset to INIT_DIV and can be read and written. A divisor below 2 acts as 2. The transmitter and the receiver each latch the divisor at the start of a frame.
- R4: Transmit status reads 1 exactly when transmit is enabled and no frame is in progress. It reads 0 out of reset.
- R5: A write to the transmit data offset while transmit status is 1 sends an 8N1 frame. The start bit is low, the data go out least significant bit first, the stop bit is high, and each bit lasts divisor clocks. Status reads 0 during the frame and reads 1 again within 12 bit periods of the write.
- R6: The serial output idles high. A write to transmit data while transmit status is 0 (busy or disabled) is ignored and starts no frame.
- R7: With receive enabled, a falling edge on the input starts a frame, and each bit is sampled near mid-period. When a frame completes with a high stop bit, receive status reads 1 and the receive data offset returns the byte.
- R8: A read of the receive data offset clears receive status. A byte that completes while status is still 1 overwrites the held byte.
- R9: A start bit that is no longer low at its mid-point is rejected as a glitch, and a frame whose stop bit samples low is discarded. Neither one sets receive status.
- R10: The receive input passes through two synchronizer flops. While receive is disabled, activity on the line is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 5 | Register byte address |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| tx_o | output | 1 | Serial output, idles high |
| rx_i | input | 1 | Serial input, asynchronous |

## Verification
The bench samples the serial output at the mid-point of each bit, counting from the falling edge. A transmitter that sent the most significant bit first, dropped the stop bit or miscounted the divisor would produce a wrong byte or a low stop bit. A write issued in the middle of a frame must neither corrupt that frame nor queue a second one, and a design that latched it would show an extra start bit on the line afterwards. On the receive side, the bench sends a one-clock low pulse, a frame with a low stop bit, back-to-back bytes with no read in between, and a frame while receive is disabled. A receiver that failed to check its start bit, accepted bad frames, kept the old byte or ignored the enable would set the ready flag or return the wrong byte. The divisor corners are a value of 1, which must behave as 2, and little-endian readback of random divisors.

// File: rtl/uart_csr_pkg.sv
package uart_csr_pkg;
  // number of payload bits in one frame
  localparam int DATA_BITS = 8;
  // start + data + stop
  localparam int FRAME_BITS = DATA_BITS + 2;

  // register offsets inside a bank (bits 3:0 of the address)
  localparam logic [3:0] OFF_CFG  = 4'h0;
  localparam logic [3:0] OFF_DIV0 = 4'h4;
  localparam logic [3:0] OFF_STAT = 4'h8;
  localparam logic [3:0] OFF_DATA = 4'h9;

  // bank select value held in the top address bit
  localparam logic BANK_RX = 1'b0;
  localparam logic BANK_TX = 1'b1;
endpackage

// File: rtl/uart_sync2.sv
module uart_sync2 #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core import uart_csr_pkg::*; #(
  parameter int DIV_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en_i,
  input  logic                 start_i,
  input  logic [DATA_BITS-1:0] byte_i,
  input  logic [DIV_W-1:0]     div_i,
  output logic                 line_o,
  output logic                 busy_o
);
  localparam int IDX_W = $clog2(FRAME_BITS + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

  // clamp: a bit period shorter than 2 clocks is raised to 2
  function automatic logic [DIV_W-1:0] bit_period(input logic [DIV_W-1:0] d);
    return (d < DIV_W'(2)) ? DIV_W'(2) : d;
  endfunction

  logic [FRAME_BITS-1:0] shift_q;
  logic [DIV_W-1:0]      cnt_q;
  logic [DIV_W-1:0]      period_q;
  logic [IDX_W-1:0]      idx_q;
  logic                  busy_q;
  logic                  bit_end;

  assign bit_end = busy_q && (cnt_q == period_q - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      shift_q  <= '1;
      cnt_q    <= '0;
      period_q <= DIV_W'(2);
      idx_q    <= '0;
    end else if (!busy_q) begin
      if (start_i && en_i) begin
        busy_q   <= 1'b1;
        shift_q  <= {1'b1, byte_i, 1'b0};
        cnt_q    <= '0;
        idx_q    <= '0;
        period_q <= bit_period(div_i);
      end
    end else if (bit_end) begin
      cnt_q   <= '0;
      shift_q <= {1'b1, shift_q[FRAME_BITS-1:1]};
      idx_q   <= idx_q + IDX_W'(1);
      if (idx_q == LAST_IDX) busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  assign line_o = busy_q ? shift_q[0] : 1'b1;
  assign busy_o = busy_q;
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core import uart_csr_pkg::*; #(
  parameter int DIV_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en_i,
  input  logic                 line_i,
  input  logic [DIV_W-1:0]     div_i,
  output logic                 done_o,
  output logic [DATA_BITS-1:0] byte_o
);
  localparam int IDX_W = $clog2(FRAME_BITS + 1);
  localparam logic [IDX_W-1:0] STOP_IDX = IDX_W'(FRAME_BITS - 1);

  function automatic logic [DIV_W-1:0] bit_period(input logic [DIV_W-1:0] d);
    return (d < DIV_W'(2)) ? DIV_W'(2) : d;
  endfunction

  // distance from the start edge to the middle of the start bit
  function automatic logic [DIV_W-1:0] half_period(input logic [DIV_W-1:0] d);
    return bit_period(d) >> 1;
  endfunction

  logic                 active_q;
  logic                 prev_q;
  logic [DIV_W-1:0]     cnt_q;
  logic [DIV_W-1:0]     target_q;
  logic [DIV_W-1:0]     period_q;
  logic [IDX_W-1:0]     idx_q;
  logic [DATA_BITS-1:0] shift_q;
  logic                 done_q;
  logic                 start_edge;
  logic                 sample_evt;
  logic                 good_stop;

  assign start_edge = en_i && !active_q && prev_q && !line_i;
  assign sample_evt = en_i && active_q && (cnt_q == target_q - DIV_W'(1));
  assign good_stop  = sample_evt && (idx_q == STOP_IDX) && line_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      prev_q   <= 1'b1;
      cnt_q    <= '0;
      target_q <= DIV_W'(1);
      period_q <= DIV_W'(2);
      idx_q    <= '0;
      shift_q  <= '0;
      done_q   <= 1'b0;
    end else begin
      prev_q <= line_i;
      done_q <= good_stop;
      if (!en_i) begin
        active_q <= 1'b0;
      end else if (start_edge) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
        idx_q    <= '0;
        target_q <= half_period(div_i);
        period_q <= bit_period(div_i);
      end else if (sample_evt) begin
        cnt_q    <= '0;
        target_q <= period_q;
        idx_q    <= idx_q + IDX_W'(1);
        if (idx_q == '0) begin
          if (line_i) active_q <= 1'b0;   // glitch, not a start bit
        end else if (idx_q == STOP_IDX) begin
          active_q <= 1'b0;
        end else begin
          shift_q <= {line_i, shift_q[DATA_BITS-1:1]};
        end
      end else if (active_q) begin
        cnt_q <= cnt_q + DIV_W'(1);
      end
    end
  end

  assign done_o = done_q;
  assign byte_o = shift_q;
endmodule

// File: rtl/uart_csr_periph.sv
module uart_csr_periph import uart_csr_pkg::*; #(
  parameter int          ADDR_W    = 5,
  parameter int          DIV_BYTES = 4,
  parameter logic [31:0] INIT_DIV  = 32'd8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              tx_o,
  input  logic              rx_i
);
  localparam int DIV_W = 8 * DIV_BYTES;
  localparam int OFF_W = ADDR_W - 1;

  logic [OFF_W-1:0]     reg_off;
  logic                 bank;
  logic                 tx_en, rx_en;
  logic [DIV_W-1:0]     tx_div, rx_div;
  logic                 rx_ready;
  logic [DATA_BITS-1:0] rx_hold;
  logic [7:0]           rdata_q, rd_val;
  logic                 tx_busy, tx_ready, tx_start;
  logic                 rx_sync, rx_done, rx_read;
  logic [DATA_BITS-1:0] rx_byte;
  logic [DIV_BYTES-1:0] div_we;
  logic [DIV_W-1:0]     div_sel;

  function automatic logic off_is(input logic [OFF_W-1:0] o, input int base, input int idx);
    return int'(o) == base + idx;
  endfunction

  assign reg_off  = bus_addr[OFF_W-1:0];
  assign bank     = bus_addr[ADDR_W-1];
  assign tx_ready = tx_en && !tx_busy;
  assign tx_start = bus_wr && (bank == BANK_TX) && off_is(reg_off, int'(OFF_DATA), 0) && tx_ready;
  assign rx_read  = bus_rd && (bank == BANK_RX) && off_is(reg_off, int'(OFF_DATA), 0);
  assign div_sel  = (bank == BANK_TX) ? tx_div : rx_div;

  for (genvar g = 0; g < DIV_BYTES; g++) begin : g_div_we
    assign div_we[g] = bus_wr && off_is(reg_off, int'(OFF_DIV0), g);
  end

  // register writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en  <= 1'b0;
      rx_en  <= 1'b0;
      tx_div <= DIV_W'(INIT_DIV);
      rx_div <= DIV_W'(INIT_DIV);
    end else if (bus_wr) begin
      if (off_is(reg_off, int'(OFF_CFG), 0)) begin
        if (bank == BANK_TX) tx_en <= bus_wdata[0];
        else                 rx_en <= bus_wdata[0];
      end
      for (int i = 0; i < DIV_BYTES; i++) begin
        if (div_we[i]) begin
          if (bank == BANK_TX) tx_div[8*i +: 8] <= bus_wdata;
          else                 rx_div[8*i +: 8] <= bus_wdata;
        end
      end
    end
  end

  // receive holding register and ready flag; a new byte wins over a read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_ready <= 1'b0;
      rx_hold  <= '0;
    end else if (rx_done) begin
      rx_ready <= 1'b1;
      rx_hold  <= rx_byte;
    end else if (rx_read) begin
      rx_ready <= 1'b0;
    end
  end

  // read mux
  always_comb begin
    rd_val = '0;
    if (off_is(reg_off, int'(OFF_CFG), 0))
      rd_val = {7'b0, (bank == BANK_TX) ? tx_en : rx_en};
    else if (off_is(reg_off, int'(OFF_STAT), 0))
      rd_val = {7'b0, (bank == BANK_TX) ? tx_ready : rx_ready};
    else if (off_is(reg_off, int'(OFF_DATA), 0))
      rd_val = (bank == BANK_TX) ? 8'h00 : rx_hold;
    else
      for (int i = 0; i < DIV_BYTES; i++)
        if (off_is(reg_off, int'(OFF_DIV0), i)) rd_val = div_sel[8*i +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_val;
  end
  assign bus_rdata = rdata_q;

  uart_tx_core #(.DIV_W(DIV_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .en_i(tx_en), .start_i(tx_start),
    .byte_i(bus_wdata), .div_i(tx_div), .line_o(tx_o), .busy_o(tx_busy)
  );

  uart_sync2 #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(rx_i), .q_o(rx_sync)
  );

  uart_rx_core #(.DIV_W(DIV_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .en_i(rx_en), .line_i(rx_sync),
    .div_i(rx_div), .done_o(rx_done), .byte_o(rx_byte)
  );
endmodule

// File: rtl/uart_csr_chk.sv
module uart_csr_chk #(
  parameter int OFF_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [OFF_W-1:0] reg_off,
  input logic             bus_rd,
  input logic [7:0]       bus_rdata,
  input logic             tx_o,
  input logic             tx_busy,
  input logic             tx_start,
  input logic             tx_ready,
  input logic             rx_done,
  input logic             rx_ready
);
  logic unmapped;
  assign unmapped = (int'(reg_off) >= 1 && int'(reg_off) <= 3) || (int'(reg_off) >= 10);

  // R2
  rd_unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && unmapped |=> bus_rdata == 8'h00);

  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  // R4
  tx_busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |-> !tx_ready);

  // R5
  tx_start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> tx_busy && !tx_o);

  // R6
  tx_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> tx_o);

  // R7
  rx_ready_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> rx_ready);
endmodule

bind uart_csr_periph uart_csr_chk #(.OFF_W(ADDR_W - 1)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_off(reg_off), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .tx_o(tx_o), .tx_busy(tx_busy), .tx_start(tx_start),
  .tx_ready(tx_ready), .rx_done(rx_done), .rx_ready(rx_ready)
);

// File: tb/tb_uart_csr_periph.sv
module tb_uart_csr_periph;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] bus_addr = '0;
  logic       bus_rd = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       tx_o;
  logic       rx_i = 1'b1;

  int checks = 0;
  int errors = 0;

  // R1 map
  localparam logic [4:0] RXB = 5'h00, TXB = 5'h10;
  localparam logic [4:0] CFG = 5'h0, DIV = 5'h4, STAT = 5'h8, DAT = 5'h9;

  uart_csr_periph dut (.*);

  always #5 clk = ~clk;

  function automatic int eff(input int d);
    return (d < 2) ? 2 : d;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); d = bus_rdata; bus_rd = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [4:0] a, input int exp);
    logic [7:0] v;
    rd(a, v);
    check(req, int'(v), exp);
  endtask

  task automatic set_div(input logic [4:0] bank, input int d);
    for (int i = 0; i < 4; i++) wr(bank | (DIV + 5'(i)), 8'(d >> (8 * i)));
  endtask

  // watches tx_o, returns byte and stop level; start sampled too
  task automatic tx_capture(input int d, output logic [7:0] b, output logic stp, output logic st);
    int p, w;
    p = eff(d); w = 0;
    while (tx_o && w < 4 * p) begin @(negedge clk); w++; end
    repeat (p / 2) @(negedge clk);
    st = tx_o;
    for (int k = 0; k < 8; k++) begin
      repeat (p) @(negedge clk);
      b[k] = tx_o;
    end
    repeat (p) @(negedge clk);
    stp = tx_o;
  endtask

  task automatic rx_send(input int d, input logic [7:0] b, input logic stp);
    @(negedge clk); rx_i = 1'b0;
    repeat (d) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      rx_i = b[k];
      repeat (d) @(negedge clk);
    end
    rx_i = stp;
    repeat (d) @(negedge clk);
    rx_i = 1'b1;
    repeat (2 * d) @(negedge clk);
  endtask

  task automatic tx_frame(input string req, input int d, input logic [7:0] b);
    logic [7:0] got; logic stp, st;
    wr(TXB | DAT, b);
    tx_capture(d, got, stp, st);
    check({req, " start"}, int'(st), 0);
    check({req, " data"}, int'(got), int'(b));
    check({req, " stop"}, int'(stp), 1);
    repeat (2 * eff(d)) @(negedge clk);
    rd_chk({req, " ready after frame"}, TXB | STAT, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] got, v;
    logic stp, st;
    int lows;
    int unsigned seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rd_chk("R4 tx status after reset", TXB | STAT, 0);
    rd_chk("R1 tx cfg after reset", TXB | CFG, 0);
    rd_chk("R7 rx status after reset", RXB | STAT, 0);
    rd_chk("R3 tx div byte0 reset", TXB | DIV, 8);
    rd_chk("R3 rx div byte1 reset", RXB | (DIV + 5'd1), 0);
    rd_chk("R2 tx data reads zero", TXB | DAT, 0);
    rd_chk("R2 unmapped 0x02", 5'h02, 0);
    check("R6 idle line high", int'(tx_o), 1);

    // R6 disabled write ignored
    wr(TXB | DAT, 8'h5A);
    lows = 0;
    repeat (40) begin @(negedge clk); if (!tx_o) lows++; end
    check("R6 no frame while disabled", lows, 0);

    // R2 unmapped writes ignored
    wr(TXB | 5'h0C, 8'hFF);
    wr(TXB | 5'h01, 8'hFF);
    rd_chk("R2 unmapped write no effect on cfg", TXB | CFG, 0);
    rd_chk("R2 unmapped 0x1C", TXB | 5'h0C, 0);

    // R4 R5 first frame
    wr(TXB | CFG, 8'h01);
    rd_chk("R4 tx ready when enabled", TXB | STAT, 1);
    wr(TXB | DAT, 8'hA5);
    fork
      tx_capture(8, got, stp, st);
      begin
        rd_chk("R5 status low during frame", TXB | STAT, 0);
        wr(TXB | DAT, 8'h3C);   // R6 busy write
      end
    join
    check("R5 start bit", int'(st), 0);
    check("R5 byte A5", int'(got), 8'hA5);
    check("R5 stop bit", int'(stp), 1);
    repeat (16) @(negedge clk);
    rd_chk("R5 ready within 12 bit periods", TXB | STAT, 1);
    lows = 0;
    repeat (40) begin @(negedge clk); if (!tx_o) lows++; end
    check("R6 busy write started no frame", lows, 0);

    // R3 clamp: divisor 1 behaves as 2
    set_div(TXB, 1);
    rd_chk("R3 div stored as written", TXB | DIV, 1);
    tx_frame("R3 clamp div1", 1, 8'h96);

    // random tx with random divisors
    for (int n = 0; n < 6; n++) begin
      int d; logic [7:0] b;
      d = 4 + int'($urandom_range(12));
      b = 8'($urandom);
      set_div(TXB, d);
      rd_chk("R1 R3 div byte0 readback", TXB | DIV, d & 8'hFF);
      rd_chk("R1 div byte3 readback", TXB | (DIV + 5'd3), 0);
      tx_frame("R5 random", d, b);
    end

    // R10 receive disabled ignores line
    rx_send(8, 8'h42, 1'b1);
    rd_chk("R10 rx disabled no ready", RXB | STAT, 0);

    // R7 basic receive
    wr(RXB | CFG, 8'h01);
    rd_chk("R7 rx not ready after enable", RXB | STAT, 0);
    rx_send(8, 8'h73, 1'b1);
    rd_chk("R7 rx ready", RXB | STAT, 1);
    rd_chk("R7 rx data 73", RXB | DAT, 8'h73);
    rd_chk("R8 read clears ready", RXB | STAT, 0);

    // R8 overwrite
    rx_send(8, 8'h11, 1'b1);
    rx_send(8, 8'hE8, 1'b1);
    rd_chk("R8 second byte overwrites", RXB | DAT, 8'hE8);

    // R9 glitch
    @(negedge clk); rx_i = 1'b0;
    @(negedge clk); rx_i = 1'b1;
    repeat (120) @(negedge clk);
    rd_chk("R9 glitch rejected", RXB | STAT, 0);

    // R9 bad stop
    rx_send(8, 8'h5C, 1'b0);
    rd_chk("R9 bad stop discarded", RXB | STAT, 0);
    rx_send(8, 8'hC3, 1'b1);
    rd_chk("R9 recovers after bad stop", RXB | DAT, 8'hC3);

    // random rx
    for (int n = 0; n < 6; n++) begin
      int d; logic [7:0] b;
      d = 4 + int'($urandom_range(12));
      b = 8'($urandom);
      set_div(RXB, d);
      rx_send(d, b, 1'b1);
      rd_chk("R7 random rx ready", RXB | STAT, 1);
      rd(RXB | DAT, v);
      check("R7 random rx byte", int'(v), int'(b));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule